// File: doc/BRIEF.md
# Dual-Style Host Processor Port

This block lets an external processor reach a small internal register file over an asynchronous parallel bus. A static style pin picks one of two handshakes. In strobe style, one chip select, a data strobe and a read/write level run each access, and an open-drain style acknowledge is pulled low when the transfer is done. In split style, separate read and write strobes run each access, and a ready line that idles low rises to mark completion. Each style shares the same two strobe pins: the data-strobe pin doubles as the read strobe, and the read/write pin doubles as the write strobe.

All bus control inputs cross into the clock domain through two-flop synchronizers. A small state machine turns every strobe pulse into exactly one single-cycle request to the register file. It holds the completion signal until the processor lets go of the strobe. Reset is filtered so that only a long enough low pulse takes effect. After reset the port stays locked for a long, parameterized stabilization window. Accesses that arrive during that window are held pending and get no completion signal until the window ends. The low byte of register 0 drives a set of active-low output-enable lines for downstream serial drivers.

Top module: `hostport_bridge`

## Requirements
- R1: `mode_mot_i` = 1 selects strobe style, in which an access needs `cs_n_i` = 0 and `ds_rd_n_i` = 0, with `rw_wr_n_i` = 1 for a read and 0 for a write. In strobe style, `rw_wr_n_i` low without `ds_rd_n_i` low starts nothing.
- R2: With `cs_n_i` = 1, no strobe pattern produces a completion signal or changes any register.
- R3: A strobe-style read returns the addressed register on `data_o`. A strobe-style write stores `data_i` into the addressed register.
- R4: In strobe style, `xack_oe_o` = 1 with `xack_o` = 0 marks completion, and the driven value is never 1. Completion is shown within 6 clock cycles of the strobe falling. Both outputs are released (`xack_oe_o` = 0) within 5 cycles of the strobe rising.
- R5: `mode_mot_i` = 0 selects split style: `ds_rd_n_i` = 0 with `cs_n_i` = 0 is a read, and `rw_wr_n_i` = 0 with `cs_n_i` = 0 is a write.
- R6: In split style, `xack_oe_o` stays 1. `xack_o` is 0 while idle or pending, goes to 1 within 6 cycles of the strobe falling, and returns to 0 within 5 cycles of the strobe rising.
- R7: A strobe held low for any length of time gives one request, and the completion signal stays asserted without a break until the strobe is released.
- R8: `data_oe_o` is 1 only during a completed read while `cs_n_i` and `ds_rd_n_i` are both low. It drops as soon as either one rises. It is 0 during writes, during reset and during the lockout window.
- R9: Addresses 0 to NREGS-1 hold registers that reset to 16'hA500 ORed with the index. Reads of any other address return 0, and writes to any other address change nothing.
- R10: `soe_n_o` equals the inverse of bits [SOE_W-1:0] of register 0, and it is all ones while reset is in effect.
- R11: A low pulse on `rst_n_i` shorter than RST_MIN_CYC cycles has no effect. A low pulse of RST_MIN_CYC+4 cycles or more resets every register and counter.
- R12: `busy_lock_o` is 1 during reset and for LOCKOUT_CYC to LOCKOUT_CYC+6 cycles after `rst_n_i` rises. An access started in that window gets no completion signal until the window ends, and is then serviced normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_n_i | input | 1 | Active-low reset request, filtered for pulse length |
| mode_mot_i | input | 1 | Handshake style: 1 strobe style, 0 split style |
| cs_n_i | input | 1 | Active-low chip select |
| ds_rd_n_i | input | 1 | Data strobe (strobe style) or read strobe (split style), active low |
| rw_wr_n_i | input | 1 | Read/write level (strobe style) or write strobe (split style) |
| addr_i | input | ADDR_W (14) | Register address |
| data_i | input | DATA_W (16) | Write data from the processor |
| data_o | output | DATA_W (16) | Read data toward the processor |
| data_oe_o | output | 1 | Enable for the data bus drivers |
| xack_o | output | 1 | Completion line value (acknowledge or ready) |
| xack_oe_o | output | 1 | Drive enable for the completion line |
| soe_n_o | output | SOE_W (8) | Active-low enables for downstream serial drivers |
| busy_lock_o | output | 1 | Port unavailable (reset or stabilization window) |

## Verification
The bench targets the edges of the handshake. A strobe held far longer than needed must keep completion asserted without a break; a design that re-armed itself would pulse it or issue a second request. A write-level change with no data strobe in strobe style must start nothing; a design that decoded the styles loosely would treat it as a split-style write. Accesses started inside the lockout window must stall and then finish; a design that dropped them would never complete, and one that ignored the lock would complete early. A reset pulse just short of the limit must leave the registers untouched, and a long one must restore them; the enable lines and the data drivers are also watched during reset.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

  // Handshake sequencer states
  typedef enum logic [1:0] {
    HB_IDLE = 2'd0,
    HB_EXEC = 2'd1,
    HB_DONE = 2'd2
  } hb_state_e;

  localparam logic [15:0] REG_DEF_BASE = 16'hA500;

  // Reset value of register idx
  function automatic logic [15:0] reg_default(input int unsigned idx);
    reg_default = REG_DEF_BASE | 16'(idx & 32'h0000_00FF);
  endfunction

endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/hbb_rst_ctl.sv
module hbb_rst_ctl #(
  parameter int RST_MIN_CYC = 200,
  parameter int LOCKOUT_CYC = 120000
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic core_rst_n_o,
  output logic locked_o
);

  localparam int LW_W = $clog2(RST_MIN_CYC + 1);
  localparam int LK_W = $clog2(LOCKOUT_CYC + 1);
  localparam logic [LW_W-1:0] LW_MAX = LW_W'(RST_MIN_CYC);
  localparam logic [LK_W-1:0] LK_MAX = LK_W'(LOCKOUT_CYC);

  logic [1:0]      pin_sync_q;
  logic [LW_W-1:0] low_cnt_q, low_cnt_d;
  logic            core_rst_n_q, core_rst_n_d;
  logic [LK_W-1:0] lk_cnt_q, lk_cnt_d;
  logic            lk_en;

  // Pulse-length qualifier: reset takes effect only after a long low level
  always_comb begin
    low_cnt_d    = low_cnt_q;
    core_rst_n_d = core_rst_n_q;
    if (pin_sync_q[1]) begin
      low_cnt_d    = '0;
      core_rst_n_d = 1'b1;
    end else if (low_cnt_q != LW_MAX) begin
      low_cnt_d = low_cnt_q + 1'b1;
    end else begin
      core_rst_n_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    pin_sync_q   <= {pin_sync_q[0], rst_n_i};
    low_cnt_q    <= low_cnt_d;
    core_rst_n_q <= core_rst_n_d;
  end

  // Stabilization window counter, cleared by the qualified reset
  assign lk_en    = (lk_cnt_q != LK_MAX);
  assign lk_cnt_d = lk_cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge core_rst_n_q) begin
    if (!core_rst_n_q) begin
      lk_cnt_q <= '0;
    end else if (lk_en) begin
      lk_cnt_q <= lk_cnt_d;
    end
  end

  assign locked_o     = lk_en;
  assign core_rst_n_o = core_rst_n_q;

endmodule

// File: rtl/hbb_regfile.sv
module hbb_regfile #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int NREGS  = 8,
  parameter int SOE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              req_vld_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [SOE_W-1:0]  soe_n_o
);

  localparam int FLAT_W = NREGS * DATA_W;

  logic [FLAT_W-1:0] flat;

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    localparam logic [DATA_W-1:0] DEF = DATA_W'(hbb_pkg::reg_default(gi));
    logic              hit;
    logic [DATA_W-1:0] val_q;

    assign hit = req_vld_i && req_wr_i && (req_addr_i == ADDR_W'(gi));

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        val_q <= DEF;
      end else if (hit) begin
        val_q <= req_wdata_i;
      end
    end

    assign flat[gi*DATA_W +: DATA_W] = val_q;
  end

  // Unmapped addresses read as zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (req_addr_i == ADDR_W'(i)) begin
        rd_data_o = flat[i*DATA_W +: DATA_W];
      end
    end
  end

  assign soe_n_o = ~flat[SOE_W-1:0];

endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
  import hbb_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 16,
  parameter int NREGS       = 8,
  parameter int SOE_W       = 8,
  parameter int RST_MIN_CYC = 200,
  parameter int LOCKOUT_CYC = 120000
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              mode_mot_i,
  input  logic              cs_n_i,
  input  logic              ds_rd_n_i,
  input  logic              rw_wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              xack_o,
  output logic              xack_oe_o,
  output logic [SOE_W-1:0]  soe_n_o,
  output logic              busy_lock_o
);

  localparam int NPINS = 4;

  logic             core_rst_n;
  logic             locked;
  logic [NPINS-1:0] pins_s;
  logic             mode_s, cs_s, ds_s, rw_s;

  hbb_rst_ctl #(
    .RST_MIN_CYC(RST_MIN_CYC),
    .LOCKOUT_CYC(LOCKOUT_CYC)
  ) u_rst (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .core_rst_n_o(core_rst_n),
    .locked_o    (locked)
  );

  // Style pin resets to 1 (strobe style) as if left undriven
  hbb_sync #(
    .W      (NPINS),
    .RST_VAL({NPINS{1'b1}})
  ) u_sync (
    .clk_i  (clk_i),
    .rst_n_i(core_rst_n),
    .d_i    ({mode_mot_i, cs_n_i, ds_rd_n_i, rw_wr_n_i}),
    .q_o    (pins_s)
  );

  assign {mode_s, cs_s, ds_s, rw_s} = pins_s;

  hb_state_e         state_q, state_d;
  logic              is_rd_q, is_rd_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              acc_act, acc_rd;
  logic              req_vld, req_wr;
  logic [DATA_W-1:0] rf_rdata;
  logic              done_on;

  // Access decode per style
  always_comb begin
    if (mode_s) begin
      acc_act = !cs_s && !ds_s;
      acc_rd  = rw_s;
    end else begin
      acc_act = !cs_s && (!ds_s || !rw_s);
      acc_rd  = !ds_s;
    end
  end

  // Handshake sequencer: one request per strobe pulse
  always_comb begin
    state_d = state_q;
    is_rd_d = is_rd_q;
    rdata_d = rdata_q;
    req_vld = 1'b0;
    req_wr  = 1'b0;
    unique case (state_q)
      HB_IDLE: begin
        if (acc_act && !locked) begin
          state_d = HB_EXEC;
          is_rd_d = acc_rd;
        end
      end
      HB_EXEC: begin
        req_vld = 1'b1;
        req_wr  = !is_rd_q;
        if (is_rd_q) begin
          rdata_d = rf_rdata;
        end
        state_d = HB_DONE;
      end
      HB_DONE: begin
        if (!acc_act) begin
          state_d = HB_IDLE;
        end
      end
      default: state_d = HB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= HB_IDLE;
      is_rd_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      is_rd_q <= is_rd_d;
      rdata_q <= rdata_d;
    end
  end

  hbb_regfile #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NREGS (NREGS),
    .SOE_W (SOE_W)
  ) u_rf (
    .clk_i      (clk_i),
    .rst_n_i    (core_rst_n),
    .req_vld_i  (req_vld),
    .req_wr_i   (req_wr),
    .req_addr_i (addr_i),
    .req_wdata_i(data_i),
    .rd_data_o  (rf_rdata),
    .soe_n_o    (soe_n_o)
  );

  assign done_on = (state_q == HB_DONE);

  // Strobe style: pull low only; split style: always driven, high when done
  assign xack_oe_o   = mode_s ? done_on : 1'b1;
  assign xack_o      = mode_s ? 1'b0 : done_on;
  assign data_o      = rdata_q;
  assign data_oe_o   = done_on && is_rd_q && !cs_n_i && !ds_rd_n_i;
  assign busy_lock_o = locked;

endmodule

// File: rtl/hostport_bridge_chk.sv
module hostport_bridge_chk #(
  parameter int SOE_W = 8
) (
  input logic             clk_i,
  input logic             core_rst_n,
  input logic             mode_s,
  input logic             cs_n_i,
  input logic             ds_rd_n_i,
  input logic             xack_o,
  input logic             xack_oe_o,
  input logic             data_oe_o,
  input logic             busy_lock_o,
  input logic [SOE_W-1:0] soe_n_o
);

  // R4
  mot_ack_low_only_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (mode_s && xack_oe_o) |-> (xack_o == 1'b0));

  // R6
  split_rdy_driven_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !mode_s |-> xack_oe_o);

  // R8
  data_drive_gate_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    data_oe_o |-> (!cs_n_i && !ds_rd_n_i && !busy_lock_o));

  // R12
  lock_no_done_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    busy_lock_o |-> !(mode_s ? xack_oe_o : xack_o));

  // R10
  rst_soe_off_chk: assert property (@(posedge clk_i)
    (!core_rst_n && $past(!core_rst_n)) |-> (&soe_n_o));

  // R12
  rst_locked_chk: assert property (@(posedge clk_i)
    (!core_rst_n && $past(!core_rst_n)) |-> busy_lock_o);

endmodule

bind hostport_bridge hostport_bridge_chk #(.SOE_W(SOE_W)) u_chk (
  .clk_i      (clk_i),
  .core_rst_n (core_rst_n),
  .mode_s     (mode_s),
  .cs_n_i     (cs_n_i),
  .ds_rd_n_i  (ds_rd_n_i),
  .xack_o     (xack_o),
  .xack_oe_o  (xack_oe_o),
  .data_oe_o  (data_oe_o),
  .busy_lock_o(busy_lock_o),
  .soe_n_o    (soe_n_o)
);

// File: tb/hostport_bridge_tb_top.sv
`timescale 1ns/1ps
module hostport_bridge_tb_top;

  localparam int RST_MIN = 16;
  localparam int LOCK    = 400;
  localparam int NREGS   = 8;

  logic        clk;
  logic        rst_n;
  logic        mode;
  logic        cs_n;
  logic        ds_n;
  logic        rw_n;
  logic [13:0] addr;
  logic [15:0] din;
  logic [15:0] data_o;
  logic        data_oe;
  logic        xack;
  logic        xack_oe;
  logic [7:0]  soe_n;
  logic        lock;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] mdl [NREGS];

  hostport_bridge #(
    .RST_MIN_CYC(RST_MIN),
    .LOCKOUT_CYC(LOCK)
  ) dut_i (
    .clk_i      (clk),
    .rst_n_i    (rst_n),
    .mode_mot_i (mode),
    .cs_n_i     (cs_n),
    .ds_rd_n_i  (ds_n),
    .rw_wr_n_i  (rw_n),
    .addr_i     (addr),
    .data_i     (din),
    .data_o     (data_o),
    .data_oe_o  (data_oe),
    .xack_o     (xack),
    .xack_oe_o  (xack_oe),
    .soe_n_o    (soe_n),
    .busy_lock_o(lock)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  function automatic bit done_seen();
    return mode ? (xack_oe === 1'b1 && xack === 1'b0) : (xack === 1'b1);
  endfunction

  function automatic logic [15:0] def_val(input int i);
    return 16'hA500 | 16'(i);
  endfunction

  function automatic logic [15:0] exp_read(input logic [13:0] a);
    return (a < 14'(NREGS)) ? mdl[a[2:0]] : 16'h0000;
  endfunction

  task automatic reset_model();
    for (int i = 0; i < NREGS; i++) mdl[i] = def_val(i);
  endtask

  task automatic bus_idle();
    cs_n = 1'b1; ds_n = 1'b1; rw_n = 1'b1;
  endtask

  task automatic no_done_for(input int n, input string req, input string what);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(!done_seen(), req, what, 32'(done_seen()), 0);
    end
  endtask

  // One complete access in the current style
  task automatic access(input bit wr, input logic [13:0] a, input logic [15:0] wd,
                        input int hold, output logic [15:0] rd);
    int lat;
    bit seen;
    @(negedge clk);
    addr = a; din = wd; cs_n = 1'b0;
    if (mode) begin
      rw_n = !wr; ds_n = 1'b0;
    end else if (wr) begin
      rw_n = 1'b0;
    end else begin
      ds_n = 1'b0;
    end
    lat = 0; seen = 0;
    while (!seen && lat < 10) begin
      @(negedge clk);
      lat++;
      seen = done_seen();
    end
    chk(seen && lat <= 6, mode ? "R4" : "R6", "completion latency", lat, 6);
    rd = data_o;
    if (!wr) begin
      chk(data_oe === 1'b1, "R8", "read drive enable", 32'(data_oe), 1);
      chk(data_o === exp_read(a), mode ? "R3" : "R5", "read data", data_o, exp_read(a));
    end else begin
      chk(data_oe === 1'b0, "R8", "no drive on write", 32'(data_oe), 0);
      if (a < 14'(NREGS)) mdl[a[2:0]] = wd;
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(done_seen(), "R7", "completion held", 32'(done_seen()), 1);
      if (wr) chk(data_oe === 1'b0, "R8", "no drive on held write", 32'(data_oe), 0);
    end
    @(negedge clk);
    bus_idle();
    #1;
    chk(data_oe === 1'b0, "R8", "drive drops with strobe", 32'(data_oe), 0);
    lat = 0;
    while (done_seen() && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk(!done_seen() && lat <= 5, mode ? "R4" : "R6", "completion release", lat, 5);
    if (mode) chk(xack_oe === 1'b0, "R4", "ack released", 32'(xack_oe), 0);
    else      chk(xack_oe === 1'b1 && xack === 1'b0, "R6", "ready back low", {xack_oe, xack}, 2);
  endtask

  task automatic wait_unlock(output int cyc);
    cyc = 0;
    while (lock && cyc < LOCK + 50) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_sim();
  end

  initial begin
    logic [15:0] rd;
    int cyc;
    int lat;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; mode = 1'b1; addr = '0; din = '0;
    bus_idle();
    reset_model();

    // Reset state
    repeat (RST_MIN + 10) @(negedge clk);
    chk(soe_n === 8'hFF, "R10", "enables off in reset", soe_n, 8'hFF);
    chk(lock === 1'b1, "R12", "locked in reset", 32'(lock), 1);
    chk(xack_oe === 1'b0, "R4", "ack released in reset", 32'(xack_oe), 0);
    chk(data_oe === 1'b0, "R8", "no drive in reset", 32'(data_oe), 0);

    // Access issued inside the lockout window stalls, then completes
    rst_n = 1'b1;
    cyc = 0;
    repeat (20) begin @(negedge clk); cyc++; end
    addr = 14'd3; cs_n = 1'b0; rw_n = 1'b1; ds_n = 1'b0;
    while (lock && cyc < LOCK + 50) begin
      @(negedge clk);
      cyc++;
      if (lock) chk(!done_seen() && data_oe === 1'b0, "R12", "no ack while locked",
                    {done_seen(), data_oe}, 0);
    end
    chk(cyc >= LOCK && cyc <= LOCK + 6, "R12", "lockout length", cyc, LOCK);
    lat = 0;
    while (!done_seen() && lat < 10) begin @(negedge clk); lat++; end
    chk(done_seen() && lat <= 6, "R12", "pending access served", lat, 6);
    chk(data_o === def_val(3), "R12", "pending read data", data_o, def_val(3));
    @(negedge clk);
    bus_idle();
    repeat (5) @(negedge clk);

    // Default register contents, strobe style
    for (int i = 0; i < NREGS; i++) begin
      access(1'b0, 14'(i), 16'h0, 0, rd);
      chk(rd === def_val(i), "R9", "reset value", rd, def_val(i));
    end

    // Enables follow register 0
    access(1'b1, 14'd0, 16'h00F0, 0, rd);
    repeat (2) @(negedge clk);
    chk(soe_n === 8'h0F, "R10", "enables from reg0", soe_n, 8'h0F);

    // Unmapped address
    access(1'b1, 14'd9, 16'h1357, 0, rd);
    access(1'b0, 14'd9, 16'h0, 0, rd);
    chk(rd === 16'h0000, "R9", "unmapped reads zero", rd, 0);
    access(1'b0, 14'd1, 16'h0, 0, rd);
    chk(rd === def_val(1), "R9", "unmapped write ignored", rd, def_val(1));

    // Chip select gating
    @(negedge clk);
    addr = 14'd2; din = 16'h1234; cs_n = 1'b1; ds_n = 1'b0; rw_n = 1'b0;
    no_done_for(15, "R2", "strobe without select");
    bus_idle();
    repeat (4) @(negedge clk);
    access(1'b0, 14'd2, 16'h0, 0, rd);
    chk(rd === mdl[2], "R2", "reg unchanged without select", rd, mdl[2]);

    // Write level alone in strobe style starts nothing
    @(negedge clk);
    addr = 14'd2; din = 16'h4321; cs_n = 1'b0; rw_n = 1'b0; ds_n = 1'b1;
    no_done_for(15, "R1", "write level without data strobe");
    bus_idle();
    repeat (4) @(negedge clk);
    access(1'b0, 14'd2, 16'h0, 0, rd);
    chk(rd === mdl[2], "R1", "reg unchanged", rd, mdl[2]);

    // Long hold
    access(1'b0, 14'd5, 16'h0, 30, rd);
    access(1'b1, 14'd6, 16'hC0DE, 20, rd);

    // Split style
    mode = 1'b0;
    repeat (4) @(negedge clk);
    chk(xack_oe === 1'b1 && xack === 1'b0, "R6", "ready idles low", {xack_oe, xack}, 2);
    access(1'b1, 14'd4, 16'hBEEF, 0, rd);
    access(1'b0, 14'd4, 16'h0, 0, rd);
    chk(rd === 16'hBEEF, "R5", "split write then read", rd, 16'hBEEF);
    access(1'b1, 14'd10, 16'h2468, 0, rd);
    access(1'b0, 14'd10, 16'h0, 0, rd);
    chk(rd === 16'h0000, "R9", "split unmapped", rd, 0);
    access(1'b0, 14'd6, 16'h0, 12, rd);

    // Random mixed traffic
    for (int n = 0; n < 80; n++) begin
      bit m;
      bit wr;
      logic [13:0] a;
      m = 1'($urandom % 2);
      if (m != mode) begin
        mode = m;
        repeat (4) @(negedge clk);
      end
      wr = 1'($urandom % 2);
      a  = 14'($urandom % 12);
      access(wr, a, 16'($urandom), int'($urandom % 3), rd);
    end
    mode = 1'b1;
    repeat (4) @(negedge clk);
    chk(soe_n === ~mdl[0][7:0], "R10", "enables after traffic", soe_n, ~mdl[0][7:0]);

    // Short reset pulse is ignored
    @(negedge clk);
    rst_n = 1'b0;
    repeat (RST_MIN - 6) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(lock === 1'b0, "R11", "short pulse no lock", 32'(lock), 0);
    for (int i = 0; i < NREGS; i++) begin
      access(1'b0, 14'(i), 16'h0, 0, rd);
      chk(rd === mdl[i], "R11", "short pulse keeps reg", rd, mdl[i]);
    end

    // Long reset pulse restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    repeat (RST_MIN + 8) @(negedge clk);
    chk(soe_n === 8'hFF, "R10", "enables off after long pulse", soe_n, 8'hFF);
    chk(lock === 1'b1, "R11", "long pulse locks", 32'(lock), 1);
    rst_n = 1'b1;
    reset_model();
    wait_unlock(cyc);
    chk(cyc >= LOCK && cyc <= LOCK + 6, "R12", "second lockout length", cyc, LOCK);
    for (int i = 0; i < NREGS; i++) begin
      access(1'b0, 14'(i), 16'h0, 0, rd);
      chk(rd === def_val(i), "R11", "defaults after long pulse", rd, def_val(i));
    end

    finish_sim();
  end

endmodule